// File: doc/BRIEF.md
# Multi-cycle integer divider

This unit divides two 64-bit integers and returns either the quotient or the remainder. It handles signed and unsigned operands, in full width or in a 32-bit word form. A caller presents the operands with a one-cycle `start` pulse and later receives a one-cycle `done` pulse. The answer sits on `result` from that pulse until the next operation completes.

Ordinary operands go through a restoring shift-and-subtract loop that produces one quotient bit per cycle from the operand magnitudes. Signs are applied after the loop. Division never traps. A zero divisor and the single signed overflow case (most negative value divided by minus one) are recognised when the operation is accepted, and their fixed results are returned on the next cycle without running the loop. While an operation iterates, `busy` is high and any new `start` is dropped.

Operation code `op`: bit 0 set means unsigned, clear means signed; bit 1 set means remainder, clear means quotient. So 00 = signed quotient, 01 = unsigned quotient, 10 = signed remainder, 11 = unsigned remainder. `word` selects the 32-bit form.

Top module: `int_divider`

## Requirements
- R1: An unsigned operation (op bit 0 = 1) with a non-zero divisor returns floor(lhs/rhs) for op 01 and lhs mod rhs for op 11, treating both operands as unsigned 64-bit values.
- R2: A signed operation (op bit 0 = 0) with a non-zero divisor, outside the overflow case, returns the quotient truncated toward zero for op 00. For op 10 it returns the remainder, which has the sign of the dividend.
- R3: When the divisor is zero, a quotient operation (op 00 or 01) returns all ones.
- R4: When the divisor is zero, a remainder operation (op 10 or 11) returns the dividend. In the word form this is the dividend after the word operand extension and the word result extension.
- R5: A signed full-width operation whose dividend is 0x8000_0000_0000_0000 and whose divisor is all ones returns the dividend as the quotient and zero as the remainder.
- R6: In the signed word form (word = 1, op bit 0 = 0), both operands are replaced by the sign extension of their bits 31:0 before dividing. Bits 63:32 of the inputs are ignored.
- R7: In the unsigned word form (word = 1, op bit 0 = 1), both operands are replaced by the zero extension of their bits 31:0 before dividing.
- R8: Every word-form result has bits 63:32 equal to copies of bit 31.
- R9: A zero-divisor or overflow operation accepted at one clock edge raises `done` with its result at the next edge, and `busy` never goes high for it.
- R10: Any other accepted operation raises `busy` at the accepting edge. `done` is a one-cycle pulse 64 edges after acceptance, `busy` falls at that same edge, and `busy` and `done` are never high together.
- R11: `start` while `busy` is high has no effect on the operation in flight or on any later result.
- R12: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept the operation on this edge when not busy |
| op | input | 2 | Operation code: bit 0 unsigned, bit 1 remainder |
| word | input | 1 | Select the 32-bit word form |
| lhs | input | 64 | Dividend |
| rhs | input | 64 | Divisor |
| busy | output | 1 | High while the shift-subtract loop runs |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient or remainder, held until the next completion |

## Verification
Fixed operand pairs cover the four sign combinations for both quotient and remainder. Swapping operand signs tells a correct sign fix-up apart from one that negates the wrong output, or that uses the divisor's sign for the remainder. Word-form cases put garbage in bits 63:32 and values near bit 31 in the low half; these separate sign extension from zero extension, on both the inputs and the output. Zero divisors, the most-negative-by-minus-one pair and a `start` pulse during iteration check the early results, their one-cycle timing and the dropping of new work. A batch of random operations is then compared cycle by cycle against a behavioural model.

// File: rtl/int_divider.sv
module int_divider #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic            word,
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  function automatic logic [XLEN-1:0] wext(input logic [XLEN-1:0] v);
    return {{HALF{v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  logic            sgn, accept, div_zero, ovf, special, a_neg, b_neg;
  logic [XLEN-1:0] ea, eb, a_mag, b_mag, special_val;

  assign sgn    = ~op[0];
  assign accept = start & ~busy;
  assign ea = word ? {{HALF{sgn & lhs[HALF-1]}}, lhs[HALF-1:0]} : lhs;
  assign eb = word ? {{HALF{sgn & rhs[HALF-1]}}, rhs[HALF-1:0]} : rhs;
  assign div_zero = (eb == '0);
  assign ovf      = sgn & (ea == MOST_NEG) & (&eb);
  assign special  = div_zero | ovf;
  assign a_neg = sgn & ea[XLEN-1];
  assign b_neg = sgn & eb[XLEN-1];
  assign a_mag = a_neg ? -ea : ea;
  assign b_mag = b_neg ? -eb : eb;
  assign special_val = div_zero ? (op[1] ? ea : '1) : (op[1] ? '0 : ea);

  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] rem_r, quo_r, dvs_r;
  logic            neg_q, neg_r, rem_sel, word_r;

  logic [XLEN:0]   shifted, trial;
  logic            fits, last;
  logic [XLEN-1:0] rem_nx, quo_nx, q_fix, r_fix, pick;

  assign shifted = {rem_r, quo_r[XLEN-1]};
  assign trial   = shifted - {1'b0, dvs_r};
  assign fits    = ~trial[XLEN];
  assign rem_nx  = fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
  assign quo_nx  = {quo_r[XLEN-2:0], fits};
  assign last    = (cnt == LAST);
  assign q_fix   = neg_q ? -quo_nx : quo_nx;
  assign r_fix   = neg_r ? -rem_nx : rem_nx;
  assign pick    = rem_sel ? r_fix : q_fix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      cnt     <= '0;
      rem_r   <= '0;
      quo_r   <= '0;
      dvs_r   <= '0;
      neg_q   <= 1'b0;
      neg_r   <= 1'b0;
      rem_sel <= 1'b0;
      word_r  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        rem_r <= rem_nx;
        quo_r <= quo_nx;
        cnt   <= cnt + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= word_r ? wext(pick) : pick;
        end
      end else if (start) begin
        word_r  <= word;
        rem_sel <= op[1];
        if (special) begin
          done   <= 1'b1;
          result <= word ? wext(special_val) : special_val;
        end else begin
          busy  <= 1'b1;
          cnt   <= '0;
          rem_r <= '0;
          quo_r <= a_mag;
          dvs_r <= b_mag;
          neg_q <= a_neg ^ b_neg;
          neg_r <= a_neg;
        end
      end
    end
  end

  assert_special_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && special |=> done && !busy);
  assert_zero_quotient_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && div_zero && !op[1] |=> result == '1);
  assert_zero_remainder_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && div_zero && op[1] |=> result == $past(word ? wext(lhs) : lhs));
  assert_overflow_rem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ovf && op[1] |=> result == '0);
  assert_busy_done_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  assert_start_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy && $stable(dvs_r) && $stable(rem_sel) && $stable(word_r));
  assert_word_sext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && word_r |-> result[XLEN-1:HALF] == {HALF{result[HALF-1]}});
endmodule

// File: tb/tb_int_divider.sv
module tb_int_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        word = 1'b0;
  logic [63:0] lhs = '0, rhs = '0;
  logic        busy, done;
  logic [63:0] result;

  int_divider #(.XLEN(64)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word(word),
    .lhs(lhs), .rhs(rhs), .busy(busy), .done(done), .result(result)
  );

  always #2 clk = ~clk;

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  string cur_req = "R12";

  logic        m_busy = 1'b0, m_done = 1'b0;
  logic [63:0] m_res = '0, m_pend = '0;
  int          m_cnt = 0;

  function automatic logic [64:0] ref_op(input logic [1:0] k, input logic w,
                                         input logic [63:0] a, input logic [63:0] b);
    logic sgn, remop, sp;
    logic [63:0] xa, xb, v;
    longint sa, sb;
    sgn = ~k[0];
    remop = k[1];
    xa = w ? (sgn ? {{32{a[31]}}, a[31:0]} : {32'h0, a[31:0]}) : a;
    xb = w ? (sgn ? {{32{b[31]}}, b[31:0]} : {32'h0, b[31:0]}) : b;
    sp = 1'b0;
    if (xb == 64'd0) begin
      v = remop ? xa : 64'hFFFF_FFFF_FFFF_FFFF;
      sp = 1'b1;
    end else if (sgn && xa == 64'h8000_0000_0000_0000 && xb == 64'hFFFF_FFFF_FFFF_FFFF) begin
      v = remop ? 64'd0 : xa;
      sp = 1'b1;
    end else if (sgn) begin
      sa = xa;
      sb = xb;
      v = remop ? 64'(sa % sb) : 64'(sa / sb);
    end else begin
      v = remop ? xa % xb : xa / xb;
    end
    if (w) v = {{32{v[31]}}, v[31:0]};
    return {sp, v};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_res = '0; m_cnt = 0;
    end else begin
      logic [64:0] r;
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 64) begin
          m_busy = 1'b0; m_done = 1'b1; m_res = m_pend;
        end
      end else if (start) begin
        r = ref_op(op, word, lhs, rhs);
        if (r[64]) begin
          m_done = 1'b1; m_res = r[63:0];
        end else begin
          m_busy = 1'b1; m_cnt = 0; m_pend = r[63:0];
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (busy !== m_busy || done !== m_done || result !== m_res) begin
      errors++;
      $display("FAIL %s busy/done/result actual %b/%b/%h expected %b/%b/%h",
               cur_req, busy, done, result, m_busy, m_done, m_res);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired during %s actual cycles %0d expected < 150000", cur_req, cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic issue(input string req, input logic [1:0] k, input logic w,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    cur_req = req;
    op = k; word = w; lhs = a; rhs = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    cur_req = "R12";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue("R1", 2'b01, 1'b0, 64'd100, 64'd7);
    issue("R1", 2'b11, 1'b0, 64'd100, 64'd7);
    issue("R1", 2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3);
    issue("R1", 2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0001);

    issue("R2", 2'b00, 1'b0, -64'd100, 64'd7);
    issue("R2", 2'b10, 1'b0, -64'd100, 64'd7);
    issue("R2", 2'b00, 1'b0, 64'd100, -64'd7);
    issue("R2", 2'b10, 1'b0, 64'd100, -64'd7);
    issue("R2", 2'b00, 1'b0, -64'd100, -64'd7);
    issue("R2", 2'b10, 1'b0, -64'd100, -64'd7);
    issue("R2", 2'b00, 1'b0, 64'h8000_0000_0000_0000, 64'd1);

    issue("R3", 2'b00, 1'b0, 64'd1234, 64'd0);
    issue("R3", 2'b01, 1'b0, 64'd1234, 64'd0);
    issue("R3", 2'b00, 1'b1, 64'd55, 64'hABCD_0000_0000_0000);

    issue("R4", 2'b10, 1'b0, -64'd77, 64'd0);
    issue("R4", 2'b11, 1'b0, 64'hDEAD_BEEF_0000_0001, 64'd0);
    issue("R4", 2'b11, 1'b1, 64'h1234_5678_8000_0005, 64'hFFFF_FFFF_0000_0000);

    issue("R5", 2'b00, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R5", 2'b10, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);

    issue("R6", 2'b00, 1'b1, 64'h1234_5678_FFFF_FF9C, 64'hABCD_0000_0000_0007);
    issue("R6", 2'b10, 1'b1, 64'h1234_5678_FFFF_FF9C, 64'hABCD_0000_0000_0007);
    issue("R6", 2'b00, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);

    issue("R7", 2'b01, 1'b1, 64'hDEAD_0000_FFFF_FFF0, 64'h0000_0001_0000_0003);
    issue("R7", 2'b11, 1'b1, 64'hDEAD_0000_FFFF_FFF0, 64'h0000_0001_0000_0003);

    issue("R8", 2'b01, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'd1);
    issue("R8", 2'b11, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFE);

    issue("R9", 2'b01, 1'b0, 64'd9, 64'd0);
    issue("R10", 2'b01, 1'b0, 64'd9, 64'd2);

    @(negedge clk);
    cur_req = "R11";
    op = 2'b01; word = 1'b0; lhs = 64'd1000; rhs = 64'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    op = 2'b00; lhs = 64'd5; rhs = 64'd0; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      logic [1:0]  k;
      logic        w;
      logic [63:0] a, b;
      k = 2'($urandom);
      w = 1'($urandom);
      a = {$urandom, $urandom};
      b = (i % 5 == 0) ? 64'({$urandom} >> (i % 32)) : {$urandom, $urandom};
      issue(k[0] ? "R1" : "R2", k, w, a, b);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule